// File: doc/BRIEF.md
# Boot Flash Serial Bridge

This block connects a simple host request/acknowledge bus to a serial flash device that holds boot code. A host memory read is translated on the fly into a flash read: the block selects the flash, shifts out the read opcode and a 24-bit address, clocks in one data byte and returns it to the host with the acknowledge. No software set-up is needed for this path, so the processor can fetch boot code straight from the flash.

A second path gives software direct control of the flash through an 8-byte I/O register window. Its base address is taken from two 8-bit configuration inputs, one for the high byte and one for the low byte. Software loads an opcode, three address bytes and an optional data byte, then starts a transaction through a control register. With a data phase, the data byte is shifted out while the byte coming back from the flash replaces it. This covers program and read commands. Without a data phase, only opcode and address are sent, which covers erase commands.

The whole function sits behind an enable strap that is captured while reset is held. When the strap is low, the block answers no host cycle and never selects the flash. A status byte reports the captured strap value in bit 1.

Top module: `spi_boot_bridge`

## Requirements
- R1: The strap input is captured while `rst` is high. `status_o` bit 1 equals the captured value and every other status bit is 0. The status does not change until the next reset.
- R2: With the strap captured low, no host request is ever acknowledged and `spi_cs_n` stays high.
- R3: A host memory read (`host_io`=0, `host_we`=0) selects the flash and sends 40 serial bits. These are opcode 03h, then `host_addr[23:0]` most-significant bit first, then 8 bits during which the flash byte is received. The received byte is returned on `host_rdata` with `host_ack`.
- R4: The serial data line follows mode 0. `spi_mosi` changes only when `spi_sck` falls or when `spi_cs_n` falls, and `spi_miso` is sampled on the rising edge of `spi_sck`.
- R5: `spi_sck` has a period of DIV system clocks (default 4) and is low whenever `spi_cs_n` is high.
- R6: I/O accesses are decoded in a window of exactly 8 byte addresses. The window starts at base {`cfg_base_hi`,`cfg_base_lo`} and is compared against `host_addr[15:0]`, so base 03F8h covers 03F8h to 03FFh. An I/O access outside the window is not acknowledged and changes no register.
- R7: Window offset 0 holds the opcode, offsets 1 to 3 hold the address bytes from high to low, and offset 4 holds the data byte. All five read back what was last written.
- R8: Writing offset 5 with bit 0 set starts a transaction, and bit 1 of the same write selects a data phase. Without a data phase the frame is 32 bits (opcode, then address). With a data phase it is 40 bits: the data byte is sent last, and the byte received during that phase replaces the data register.
- R9: No host request is acknowledged while a serial transaction is in progress. `host_ack` is a single-cycle pulse.
- R10: `spi_cs_n` stays high for at least one clock between two transactions.
- R11: Offset 6 reads the busy flag in bit 0 and offset 7 reads the status byte. Writes to either offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; the strap is captured while it is high |
| strap_en | input | 1 | Enable strap |
| cfg_base_hi | input | 8 | High byte of the I/O window base |
| cfg_base_lo | input | 8 | Low byte of the I/O window base |
| host_req | input | 1 | Host request, held until acknowledged |
| host_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 24 | Memory address; bits 15:0 are used for I/O |
| host_wdata | input | 8 | Write data |
| host_ack | output | 1 | One-cycle acknowledge |
| host_rdata | output | 8 | Read data, valid with `host_ack` |
| status_o | output | 8 | Status byte, bit 1 = function enabled |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Flash chip enable, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions check the following on every clock cycle:
- the serial clock is parked low while the flash is deselected;
- `spi_mosi` changes only when the clock falls (mode 0);
- the acknowledge is a single-cycle pulse;
- the chip enable stays high across the cycle after it rises;
- a disabled bridge stays silent;
- the status byte is frozen between resets.

Some behaviour only the bench scenarios can show:
- frame content and length for memory reads, erase commands and program commands;
- the byte returned from the flash model;
- window decoding at both edges and after the base is moved;
- register readback, and writes to the read-only offsets being ignored;
- the host being held off during a command;
- the measured clock period.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
  localparam int ADDR_BYTES = 3;
  localparam int FRAME_W    = 8 + 8 * ADDR_BYTES + 8;
  localparam int NBITS_W    = $clog2(FRAME_W + 1);
  localparam int WIN_SIZE   = 8;
  localparam logic [7:0] RD_OPCODE = 8'h03;

  localparam logic [2:0] OFF_OPC  = 3'd0;
  localparam logic [2:0] OFF_DATA = 3'd4;
  localparam logic [2:0] OFF_CTRL = 3'd5;
  localparam logic [2:0] OFF_BUSY = 3'd6;
  localparam logic [2:0] OFF_STAT = 3'd7;

  typedef enum logic [1:0] {H_IDLE, H_MEM, H_CMD} host_st_t;
  typedef enum logic [1:0] {E_IDLE, E_RUN, E_GAP} eng_st_t;

  function automatic logic [15:0] win_delta(input logic [15:0] a, input logic [15:0] base);
    return a - base;
  endfunction

  function automatic logic win_hit(input logic [15:0] a, input logic [15:0] base);
    return win_delta(a, base) < 16'(WIN_SIZE);
  endfunction

  function automatic logic [2:0] win_off(input logic [15:0] a, input logic [15:0] base);
    logic [15:0] d;
    d = win_delta(a, base);
    return d[2:0];
  endfunction

  function automatic logic [NBITS_W-1:0] frame_len(input logic with_data);
    return with_data ? NBITS_W'(FRAME_W) : NBITS_W'(FRAME_W - 8);
  endfunction
endpackage

// File: rtl/spi_serial_engine.sv
module spi_serial_engine
  import spi_bridge_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [NBITS_W-1:0] nbits,
  output logic               busy,
  output logic               done,
  output logic [7:0]         rx_byte,
  output logic               sck,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  localparam int HALF  = DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

  eng_st_t            st;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh;
  logic [NBITS_W-1:0] left;
  logic               half_end;

  assign half_end = (cnt == CNT_W'(HALF - 1));
  assign busy     = (st != E_IDLE);
  assign done     = (st == E_GAP) && half_end;
  assign mosi     = sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= E_IDLE; cnt <= '0; sh <= '0; left <= '0;
      sck <= 1'b0; cs_n <= 1'b1; rx_byte <= 8'h00;
    end else begin
      case (st)
        E_IDLE: if (start) begin
          sh <= frame; left <= nbits; cnt <= '0;
          sck <= 1'b0; cs_n <= 1'b0; st <= E_RUN;
        end
        E_RUN: if (half_end) begin
          cnt <= '0;
          if (!sck) begin
            sck     <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sck  <= 1'b0;
            sh   <= {sh[FRAME_W-2:0], 1'b0};
            left <= left - NBITS_W'(1);
            if (left == NBITS_W'(1)) begin
              cs_n <= 1'b1;
              st   <= E_GAP;
            end
          end
        end else cnt <= cnt + CNT_W'(1);
        E_GAP: if (half_end) begin
          cnt <= '0; st <= E_IDLE;
        end else cnt <= cnt + CNT_W'(1);
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_bridge_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         off,
  input  logic [7:0]         wdata,
  input  logic               rx_load,
  input  logic [7:0]         rx_byte,
  input  logic               busy,
  input  logic [7:0]         status,
  output logic [7:0]         rd_data,
  output logic               start,
  output logic               with_data,
  output logic [FRAME_W-1:0] frame
);
  logic [7:0] opc;
  logic [7:0] adr [ADDR_BYTES];
  logic [7:0] dat;

  assign start = wr_en && (off == OFF_CTRL) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      opc <= 8'h00; dat <= 8'h00; with_data <= 1'b0;
      for (int i = 0; i < ADDR_BYTES; i++) adr[i] <= 8'h00;
    end else begin
      if (wr_en) begin
        if (off == OFF_OPC) opc <= wdata;
        if (off == OFF_DATA) dat <= wdata;
        if (off == OFF_CTRL) with_data <= wdata[1];
        for (int i = 0; i < ADDR_BYTES; i++)
          if (off == 3'(i + 1)) adr[i] <= wdata;
      end
      if (rx_load) dat <= rx_byte;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    case (off)
      OFF_OPC:  rd_data = opc;
      OFF_DATA: rd_data = dat;
      OFF_CTRL: rd_data = {6'b0, with_data, 1'b0};
      OFF_BUSY: rd_data = {7'b0, busy};
      OFF_STAT: rd_data = status;
      default:  rd_data = adr[off - 3'd1];
    endcase
  end

  generate
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
      assign frame[FRAME_W-9-8*g -: 8] = adr[g];
    end
  endgenerate
  assign frame[FRAME_W-1 -: 8] = opc;
  assign frame[7:0]            = dat;
endmodule

// File: rtl/spi_boot_bridge.sv
module spi_boot_bridge
  import spi_bridge_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        strap_en,
  input  logic [7:0]  cfg_base_hi,
  input  logic [7:0]  cfg_base_lo,
  input  logic        host_req,
  input  logic        host_io,
  input  logic        host_we,
  input  logic [23:0] host_addr,
  input  logic [7:0]  host_wdata,
  output logic        host_ack,
  output logic [7:0]  host_rdata,
  output logic [7:0]  status_o,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  host_st_t           st;
  logic               en_q;
  logic [15:0]        base;
  logic               accept, mem_go, io_go, reg_wr, cmd_start, with_data;
  logic               eng_start, eng_busy, eng_done, rx_load;
  logic [7:0]         eng_rx, reg_rd;
  logic [2:0]         off;
  logic [FRAME_W-1:0] reg_frame, eng_frame;
  logic [NBITS_W-1:0] eng_nbits;

  assign base      = {cfg_base_hi, cfg_base_lo};
  assign off       = win_off(host_addr[15:0], base);
  assign status_o  = {6'b0, en_q, 1'b0};
  assign accept    = en_q && (st == H_IDLE) && !host_ack && !eng_busy && host_req;
  assign mem_go    = accept && !host_io && !host_we;
  assign io_go     = accept && host_io && win_hit(host_addr[15:0], base);
  assign reg_wr    = io_go && host_we;
  assign eng_start = mem_go || cmd_start;
  assign eng_frame = mem_go ? {RD_OPCODE, host_addr, 8'h00} : reg_frame;
  assign eng_nbits = mem_go ? frame_len(1'b1) : frame_len(host_wdata[1]);
  assign rx_load   = (st == H_CMD) && eng_done && with_data;

  spi_cmd_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .off(off), .wdata(host_wdata),
    .rx_load(rx_load), .rx_byte(eng_rx), .busy(eng_busy), .status(status_o),
    .rd_data(reg_rd), .start(cmd_start), .with_data(with_data), .frame(reg_frame)
  );

  spi_serial_engine #(.DIV(DIV)) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .frame(eng_frame), .nbits(eng_nbits),
    .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= strap_en; st <= H_IDLE; host_ack <= 1'b0; host_rdata <= 8'h00;
    end else begin
      host_ack <= 1'b0;
      case (st)
        H_IDLE: begin
          if (mem_go) st <= H_MEM;
          else if (io_go) begin
            host_ack <= 1'b1;
            if (!host_we) host_rdata <= reg_rd;
            if (cmd_start) st <= H_CMD;
          end
        end
        H_MEM: if (eng_done) begin
          host_rdata <= eng_rx; host_ack <= 1'b1; st <= H_IDLE;
        end
        H_CMD: if (eng_done) st <= H_IDLE;
        default: st <= H_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_bridge_chk.sv
module spi_bridge_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_ack,
  input logic [7:0] status_o,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic       spi_mosi,
  input logic       eng_done
);
  p_status_fixed_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(status_o));
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !status_o[1] |-> (spi_cs_n && !host_ack));
  p_mosi_mode0_r4: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && $past(!spi_cs_n) && !$fell(spi_sck)) |-> $stable(spi_mosi));
  p_sck_parked_r5: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);
  p_cs_gap_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |=> spi_cs_n);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    eng_done |-> spi_cs_n);
endmodule

bind spi_boot_bridge spi_bridge_chk u_chk (
  .clk(clk), .rst(rst), .host_ack(host_ack), .status_o(status_o),
  .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .eng_done(eng_done)
);

// File: tb/sim_spi_boot_bridge.sv
module sim_spi_boot_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0, rst = 1'b1, strap_en = 1'b1;
  logic [7:0] cfg_base_hi = 8'h03, cfg_base_lo = 8'hF8;
  logic host_req = 1'b0, host_io = 1'b0, host_we = 1'b0;
  logic [23:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_ack;
  logic [7:0] host_rdata, status_o;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_boot_bridge #(.DIV(DIV)) u0 (.*);

  // flash model: mode 0, response byte = low address byte ^ 5Ah
  logic [39:0] cap, last_cap;
  int nb = 0, last_nb = 0, nframes = 0;
  logic [7:0] resp = 8'h00;
  always @(negedge spi_cs_n) begin nb = 0; cap = '0; spi_miso = 1'b0; end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    cap = {cap[38:0], spi_mosi}; nb++;
    if (nb == 32) resp = cap[7:0] ^ 8'h5A;
  end
  always @(negedge spi_sck) if (!spi_cs_n)
    spi_miso = (nb >= 32 && nb < 40) ? resp[39-nb] : 1'b0;
  always @(posedge spi_cs_n) begin last_cap = cap; last_nb = nb; nframes++; end

  // timing monitors
  int cyc = 0, last_rise = 0, min_per = 1000, max_per = 0, hi_run = 0, min_gap = 1000;
  int mosi_bad = 0, cs_low_cnt = 0;
  bit have_rise = 0, ended = 0;
  logic p_sck = 0, p_cs = 1, p_mosi = 0;
  always @(negedge clk) begin
    cyc++;
    if (!spi_cs_n) cs_low_cnt++;
    if (spi_sck && !p_sck) begin
      if (have_rise) begin
        if (cyc - last_rise < min_per) min_per = cyc - last_rise;
        if (cyc - last_rise > max_per) max_per = cyc - last_rise;
      end
      have_rise = 1; last_rise = cyc;
    end
    if (spi_cs_n) have_rise = 0;
    if (!spi_cs_n && !p_cs && spi_sck && spi_mosi !== p_mosi) mosi_bad++;
    if (spi_cs_n) hi_run++;
    if (!spi_cs_n && p_cs && ended && hi_run < min_gap) min_gap = hi_run;
    if (spi_cs_n && !p_cs) ended = 1;
    if (!spi_cs_n) hi_run = 0;
    p_sck = spi_sck; p_cs = spi_cs_n; p_mosi = spi_mosi;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic host_cycle(input bit io, input bit we, input logic [23:0] a,
                            input logic [7:0] wd, input int maxw,
                            output bit acked, output logic [7:0] rd, output int waited);
    @(negedge clk);
    host_req = 1; host_io = io; host_we = we; host_addr = a; host_wdata = wd;
    acked = 0; rd = 8'h00; waited = 0;
    for (int i = 0; i < maxw; i++) begin
      @(negedge clk); waited++;
      if (host_ack) begin acked = 1; rd = host_rdata; break; end
    end
    host_req = 0; host_we = 0;
  endtask

  task automatic do_reset(input bit strap);
    strap_en = strap; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (spi_cs_n && i > 10) break;
    end
  endtask

  task automatic t_reset_state();
    chk(status_o == 8'h02, "R1", "status after enabled reset", status_o, 8'h02);
    chk(spi_cs_n && !spi_sck && !host_ack, "R5", "idle pins", {spi_cs_n, spi_sck, host_ack}, 3'b100);
  endtask

  task automatic t_mem_read(input logic [23:0] a);
    bit ak; logic [7:0] rd; int w;
    host_cycle(0, 0, a, 8'h00, 400, ak, rd, w);
    chk(ak, "R3", "memory read acknowledged", ak, 1);
    chk(rd == (a[7:0] ^ 8'h5A), "R3", "memory read data", rd, a[7:0] ^ 8'h5A);
    chk(last_nb == 40, "R3", "memory frame length", last_nb, 40);
    chk(last_cap[39:8] == {8'h03, a}, "R3", "opcode and address", last_cap[39:8], {8'h03, a});
  endtask

  task automatic t_clock_shape();
    chk(min_per == DIV && max_per == DIV, "R5", "sck period", min_per, DIV);
    chk(mosi_bad == 0, "R4", "mosi changes while sck high", mosi_bad, 0);
  endtask

  task automatic t_regs_window();
    bit ak; logic [7:0] rd; int w;
    for (int k = 0; k < 5; k++) host_cycle(1, 1, 24'h0003F8 + k, 8'h10 + 8'(k), 20, ak, rd, w);
    for (int k = 0; k < 5; k++) begin
      host_cycle(1, 0, 24'h0003F8 + k, 8'h00, 20, ak, rd, w);
      chk(ak && rd == 8'h10 + 8'(k), "R7", "register readback", rd, 8'h10 + 8'(k));
    end
    host_cycle(1, 1, 24'h0003F7, 8'hEE, 20, ak, rd, w);
    chk(!ak, "R6", "below window not acked", ak, 0);
    host_cycle(1, 1, 24'h000400, 8'hEE, 20, ak, rd, w);
    chk(!ak, "R6", "above window not acked", ak, 0);
    host_cycle(1, 0, 24'h0003FF, 8'h00, 20, ak, rd, w);
    chk(ak && rd == 8'h02, "R6", "last window byte is status", rd, 8'h02);
    host_cycle(1, 0, 24'h0003F8, 8'h00, 20, ak, rd, w);
    chk(rd == 8'h10, "R6", "opcode untouched by outside writes", rd, 8'h10);
  endtask

  task automatic t_erase_holdoff();
    bit ak; logic [7:0] rd; int w, f0;
    host_cycle(1, 1, 24'h0003F8, 8'hD8, 20, ak, rd, w);
    host_cycle(1, 1, 24'h0003F9, 8'h0A, 20, ak, rd, w);
    host_cycle(1, 1, 24'h0003FA, 8'h0B, 20, ak, rd, w);
    host_cycle(1, 1, 24'h0003FB, 8'h0C, 20, ak, rd, w);
    f0 = nframes;
    host_cycle(1, 1, 24'h0003FD, 8'h01, 20, ak, rd, w);
    host_cycle(1, 0, 24'h0003F8, 8'h00, 400, ak, rd, w);
    chk(ak && w >= 32 * DIV, "R9", "read held off during command", w, 32 * DIV);
    chk(spi_cs_n == 1, "R9", "flash deselected at ack", spi_cs_n, 1);
    chk(nframes == f0 + 1 && last_nb == 32, "R8", "erase frame length", last_nb, 32);
    chk(last_cap[31:0] == 32'hD80A0B0C, "R8", "erase frame bits", last_cap[31:0], 32'hD80A0B0C);
  endtask

  task automatic t_program();
    bit ak; logic [7:0] rd; int w;
    host_cycle(1, 1, 24'h0003F8, 8'h02, 20, ak, rd, w);
    host_cycle(1, 1, 24'h0003FB, 8'h77, 20, ak, rd, w);
    host_cycle(1, 1, 24'h0003FC, 8'hC3, 20, ak, rd, w);
    host_cycle(1, 1, 24'h0003FD, 8'h03, 20, ak, rd, w);
    wait_idle();
    chk(last_nb == 40 && last_cap[7:0] == 8'hC3, "R8", "program data byte sent", last_cap[7:0], 8'hC3);
    host_cycle(1, 0, 24'h0003FC, 8'h00, 400, ak, rd, w);
    chk(rd == (8'h77 ^ 8'h5A), "R8", "data register holds received byte", rd, 8'h77 ^ 8'h5A);
    chk(min_gap >= 1, "R10", "chip enable gap", min_gap, 1);
  endtask

  task automatic t_readonly();
    bit ak; logic [7:0] rd; int w;
    host_cycle(1, 1, 24'h0003FE, 8'hFF, 20, ak, rd, w);
    host_cycle(1, 1, 24'h0003FF, 8'hFF, 20, ak, rd, w);
    host_cycle(1, 0, 24'h0003FE, 8'h00, 20, ak, rd, w);
    chk(rd == 8'h00, "R11", "busy offset ignores write", rd, 8'h00);
    host_cycle(1, 0, 24'h0003FF, 8'h00, 20, ak, rd, w);
    chk(rd == 8'h02 && status_o == 8'h02, "R11", "status offset ignores write", rd, 8'h02);
  endtask

  task automatic t_relocate();
    bit ak; logic [7:0] rd; int w;
    cfg_base_hi = 8'h12; cfg_base_lo = 8'h34;
    host_cycle(1, 1, 24'h00123B, 8'h5C, 20, ak, rd, w);
    chk(ak, "R6", "relocated window top acked", ak, 1);
    host_cycle(1, 0, 24'h0003F8, 8'h00, 20, ak, rd, w);
    chk(!ak, "R6", "old base not acked", ak, 0);
    host_cycle(1, 0, 24'h001234, 8'h00, 20, ak, rd, w);
    chk(ak && rd == 8'h02, "R6", "relocated opcode readback", rd, 8'h02);
    cfg_base_hi = 8'h03; cfg_base_lo = 8'hF8;
  endtask

  task automatic t_disabled();
    bit ak; logic [7:0] rd; int w;
    do_reset(0);
    strap_en = 1;
    chk(status_o == 8'h00, "R1", "status after disabled reset", status_o, 8'h00);
    cs_low_cnt = 0;
    host_cycle(0, 0, 24'h000100, 8'h00, 300, ak, rd, w);
    chk(!ak, "R2", "memory read ignored when disabled", ak, 0);
    host_cycle(1, 1, 24'h0003FD, 8'h01, 50, ak, rd, w);
    chk(!ak && cs_low_cnt == 0, "R2", "flash never selected", cs_low_cnt, 0);
    chk(status_o == 8'h00, "R1", "status ignores strap after reset", status_o, 8'h00);
  endtask

  initial begin
    do_reset(1);
    t_reset_state();
    t_mem_read(24'h123456);
    t_mem_read(24'hA5C3F1);
    t_clock_shape();
    t_regs_window();
    t_erase_holdoff();
    t_program();
    t_readonly();
    t_relocate();
    t_clock_shape();
    t_disabled();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule